// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiator side of a synchronous, multiplexed address/data bus. A local client hands it one request at a time: a command, a start address and a word count. The initiator waits for its grant and opens a tenure by pulling the active-low frame line. It drives the command and the start address for one cycle and then moves data words. A word moves only on a rising edge where both the initiator-ready and target-ready lines are low. Every bus input is sampled on the rising edge.

Write data comes from the client through a show-ahead port: the word to send is on `wrData`, and `wrTake` marks the cycle in which that word moves. Read data goes back to the client through a registered valid/data pair. Reads put a turnaround cycle between the address and the first data cycle, so that the target can take over the shared lines. There is no limit on the burst length other than the width of the count. The frame line rises while the last word is pending. A target stop ends the tenure early, and a removed grant makes the next word the last one. In both cases the initiator reports the words moved in that tenure, arbitrates again and continues at the next address until the request is complete.

Top module: `burst_initiator`

## Requirements
- R1: After reset `frameN` and `irdyN` are high, `adOe` is low, `reqReady` is high and `doneValid` is low.
- R2: An address phase is a cycle with `frameN` low, `irdyN` high and `adOe` high. In it `adOut` carries the current word address and `cbeOut` carries the command. It starts only when `gntN` was low in the cycle before, and it always follows a cycle in which both `frameN` and `irdyN` were high.
- R3: A word moves on a rising edge only when `irdyN` and `trdyN` are both low. A target that holds `trdyN` high stalls the burst. Successive words go to addresses 4 apart. On a write, `adOut` shows `wrData` in the data cycle and `wrTake` is high exactly in the cycles where a word moves.
- R4: Command bit 0 high selects a write and low selects a read. A read puts one turnaround cycle after the address phase, with `adOe` low and `irdyN` high. Each read word appears on `rdData` with `rdValid` high in the cycle after the edge on which it moved.
- R5: During data cycles `frameN` is high exactly when the pending word is the last word of the request, as long as the grant stays present. In the cycle after the final word of a tenure, `frameN` and `irdyN` are both high.
- R6: `stopN` sampled low in a data cycle ends the tenure. The word also moves if `trdyN` is low on that edge. In the next cycle `frameN` and `irdyN` are high and `discValid` pulses, with `discCount` equal to the words moved in that tenure.
- R7: After a tenure that ends early with words still owed, the initiator arbitrates again. It opens a new address phase at the address of the next unsent word and moves only the remaining words.
- R8: `gntN` sampled high during a tenure forces `frameN` high from the next cycle on, so at most one more word moves before the bus is released.
- R9: `reqReady` drops in the cycle after a request is accepted. `doneValid` pulses for one cycle right after the last word of the request has moved, and then the block accepts a new request.
- R10: A single request may carry any count from 1 up to 2^CNT_W-1 words. Tenures of many words run without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Local request present |
| reqReady | output | 1 | Block idle, request accepted this cycle |
| reqCmd | input | CMD_W | Bus command, bit 0 high for write |
| reqAddr | input | DATA_W | Start byte address |
| reqCount | input | CNT_W | Number of words, nonzero |
| wrData | input | DATA_W | Next write word (show-ahead) |
| wrTake | output | 1 | Write word consumed this cycle |
| rdValid | output | 1 | Read word valid |
| rdData | output | DATA_W | Read word |
| doneValid | output | 1 | Request complete pulse |
| discValid | output | 1 | Tenure ended by target stop |
| discCount | output | CNT_W | Words moved in the stopped tenure |
| gntN | input | 1 | Bus grant, active low |
| frameN | output | 1 | Frame, active low |
| irdyN | output | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| stopN | input | 1 | Target stop, active low |
| adOut | output | DATA_W | Address/data lines, driven value |
| adIn | input | DATA_W | Address/data lines, received value |
| adOe | output | 1 | Drive enable for the address/data lines |
| cbeOut | output | CMD_W | Command in address phase, byte enables (all low) after |

## Verification
The bench builds the block with its defaults: a 32-bit bus, a 4-bit command and a 16-bit count. With these widths a 40-word burst, and stops and grant removal several words into a request, fall within reach in a short run. A target model in the bench answers every tenure with one of two patterns. It is either always ready or ready only on alternate cycles, and it can stop with or without data at a chosen word. This exercises stalls, early final-word signalling, resumption at the next address and re-arbitration after a lost grant, for both reads and writes.

// File: rtl/burst_init_pkg.sv
package burst_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_TURN,
    ST_DATA,
    ST_GAP
  } busState_e;

  typedef struct packed {
    logic load;
    logic xfer;
    logic tenureClr;
    logic addrPhase;
  } dpStrobe_t;
endpackage

// File: rtl/burst_init_ctrl.sv
module burst_init_ctrl
  import burst_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       gntN,
  input  logic       trdyN,
  input  logic       stopN,
  input  logic       remainOne,
  input  logic       remainZero,
  input  logic       isWrite,
  output dpStrobe_t  strobe,
  output logic       frameN,
  output logic       irdyN,
  output logic       adOe,
  output logic       reqReady,
  output logic       wrTake,
  output logic       doneValid,
  output logic       discValid
);
  busState_e state, stateNext;
  logic gntLost, stopSeen;
  logic lastWord, xfer, stopHit, tenureEnd, inTenure;

  assign lastWord  = remainOne || gntLost;
  assign xfer      = (state == ST_DATA) && !trdyN;
  assign stopHit   = (state == ST_DATA) && !stopN;
  assign tenureEnd = stopHit || (xfer && lastWord);
  assign inTenure  = (state == ST_ADDR) || (state == ST_TURN) || (state == ST_DATA);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_WAIT;
      ST_WAIT: if (!gntN) stateNext = ST_ADDR;
      ST_ADDR: stateNext = isWrite ? ST_DATA : ST_TURN;
      ST_TURN: stateNext = ST_DATA;
      ST_DATA: if (tenureEnd) stateNext = ST_GAP;
      ST_GAP:  stateNext = remainZero ? ST_IDLE : ST_WAIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gntLost  <= 1'b0;
      stopSeen <= 1'b0;
    end else begin
      state    <= stateNext;
      stopSeen <= stopHit;
      if (state == ST_GAP) gntLost <= 1'b0;
      else if (inTenure && gntN) gntLost <= 1'b1;
    end
  end

  assign strobe.load      = (state == ST_IDLE) && reqValid;
  assign strobe.xfer      = xfer;
  assign strobe.tenureClr = (state == ST_WAIT);
  assign strobe.addrPhase = (state == ST_ADDR);

  assign frameN    = !((state == ST_ADDR) || (state == ST_TURN) ||
                       ((state == ST_DATA) && !lastWord));
  assign irdyN     = (state != ST_DATA);
  assign adOe      = (state == ST_ADDR) || ((state == ST_DATA) && isWrite);
  assign reqReady  = (state == ST_IDLE);
  assign wrTake    = xfer && isWrite;
  assign doneValid = (state == ST_GAP) && remainZero;
  assign discValid = (state == ST_GAP) && stopSeen;
endmodule

// File: rtl/burst_init_dpath.sv
module burst_init_dpath
  import burst_init_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic [CMD_W-1:0]  cbeOut,
  output logic              isWrite,
  output logic              remainOne,
  output logic              remainZero,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  discCount
);
  localparam int ADDR_STEP = DATA_W / 8;

  logic [DATA_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain, tenureCnt;
  logic [CMD_W-1:0]  cmdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      remain    <= '0;
      tenureCnt <= '0;
      cmdQ      <= '0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      rdValid <= strobe.xfer && !isWrite;
      if (strobe.xfer && !isWrite) rdData <= adIn;
      if (strobe.load) begin
        curAddr <= reqAddr;
        remain  <= reqCount;
        cmdQ    <= reqCmd;
      end else if (strobe.xfer) begin
        curAddr <= curAddr + DATA_W'(ADDR_STEP);
        remain  <= remain - 1'b1;
      end
      if (strobe.tenureClr) tenureCnt <= '0;
      else if (strobe.xfer) tenureCnt <= tenureCnt + 1'b1;
    end
  end

  assign isWrite    = cmdQ[0];
  assign remainOne  = (remain == CNT_W'(1));
  assign remainZero = (remain == '0);
  assign adOut      = strobe.addrPhase ? curAddr : wrData;
  assign cbeOut     = strobe.addrPhase ? cmdQ : '0;
  assign discCount  = tenureCnt;
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import burst_init_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrTake,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              doneValid,
  output logic              discValid,
  output logic [CNT_W-1:0]  discCount,
  input  logic              gntN,
  output logic              frameN,
  output logic              irdyN,
  input  logic              trdyN,
  input  logic              stopN,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic [CMD_W-1:0]  cbeOut
);
  dpStrobe_t strobe;
  logic isWrite, remainOne, remainZero;

  burst_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .gntN(gntN),
    .trdyN(trdyN), .stopN(stopN), .remainOne(remainOne),
    .remainZero(remainZero), .isWrite(isWrite), .strobe(strobe),
    .frameN(frameN), .irdyN(irdyN), .adOe(adOe), .reqReady(reqReady),
    .wrTake(wrTake), .doneValid(doneValid), .discValid(discValid)
  );

  burst_init_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqCount(reqCount), .wrData(wrData), .adIn(adIn),
    .adOut(adOut), .cbeOut(cbeOut), .isWrite(isWrite),
    .remainOne(remainOne), .remainZero(remainZero), .rdValid(rdValid),
    .rdData(rdData), .discCount(discCount)
  );
endmodule

// File: rtl/burst_initiator_chk.sv
module burst_initiator_chk #(
  parameter int CMD_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             gntN,
  input logic             frameN,
  input logic             irdyN,
  input logic             trdyN,
  input logic             stopN,
  input logic             adOe,
  input logic [CMD_W-1:0] cbeOut,
  input logic             rdValid,
  input logic             discValid
);
  // R2
  addr_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> $past(frameN && irdyN));

  // R2
  addr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameN) |-> $past(!gntN));

  // R4
  read_turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameN) && !cbeOut[0]) |=> (!adOe && irdyN));

  // R3
  read_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!irdyN && !trdyN));

  // R5
  frame_stays_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && !irdyN) |=> frameN);

  // R5
  irdy_after_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irdyN) |-> frameN);

  // R6
  disc_from_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    discValid |-> ($past(!stopN) && frameN && irdyN));
endmodule

bind burst_initiator burst_initiator_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rstN(rstN), .gntN(gntN), .frameN(frameN), .irdyN(irdyN),
  .trdyN(trdyN), .stopN(stopN), .adOe(adOe), .cbeOut(cbeOut),
  .rdValid(rdValid), .discValid(discValid)
);

// File: tb/burst_initiator_tb.sv
module burst_initiator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int CMD_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [CMD_W-1:0] reqCmd = '0;
  logic [DATA_W-1:0] reqAddr = '0;
  logic [CNT_W-1:0] reqCount = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrTake, rdValid, doneValid, discValid;
  logic [DATA_W-1:0] rdData, adOut;
  logic [CNT_W-1:0] discCount;
  logic gntN = 1'b0;
  logic frameN, irdyN, adOe;
  logic trdyN = 1'b1;
  logic stopN = 1'b1;
  logic [DATA_W-1:0] adIn = '0;
  logic [CMD_W-1:0] cbeOut;

  burst_initiator #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] expAddr[$];
  logic [DATA_W-1:0] expData[$];
  logic [CMD_W-1:0] expCmd;
  bit expWrite;
  int reqRemain = 0;
  bit doneSeen = 0;

  int stallMode = 0;
  bit stopArm = 0;
  int stopAt = 0;
  bit stopWithData = 0;
  int discExpect = 0;
  bit gntArm = 0;
  int gntDropAt = 0;
  int gntHold = 0;
  int reqTotal = 0;

  logic [DATA_W-1:0] tAddr = '0;
  int tenureWords = 0;
  bit tenureGntOk = 0;
  bit turnPending = 0;
  bit endFlag = 0;
  bit prevFrame = 1, prevIrdy = 1, prevGnt = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rdWord(input logic [DATA_W-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5AC3_0F1E;
  endfunction

  // scoreboard monitor and target model, all at the falling edge
  always @(negedge clk) begin
    bit xferNow;
    if (rstN) begin
      cyc++;
      if (rdValid) begin
        if (expData.size() == 0) check(0, "R4 unexpected read word", rdData, 0);
        else begin
          check(rdData == expData[0], "R4 read word", rdData, expData[0]);
          void'(expAddr.pop_front());
          void'(expData.pop_front());
        end
      end
      if (doneValid) begin
        check(reqRemain == 0, "R9 done with words owed", reqRemain, 0);
        check(expData.size() == 0, "R9 done with queue left", expData.size(), 0);
        doneSeen = 1;
      end
      if (discValid)
        check(discCount == CNT_W'(discExpect), "R6 disconnect count", discCount, discExpect);

      if (gntN) tenureGntOk = 0;
      if (endFlag) begin
        check(frameN && irdyN, "R5 bus released after final word", {frameN, irdyN}, 2'b11);
        endFlag = 0;
      end
      if (!frameN && irdyN && adOe) begin
        check(prevFrame && prevIrdy, "R2 idle before address", {prevFrame, prevIrdy}, 2'b11);
        check(!prevGnt, "R2 grant before address", prevGnt, 0);
        check(expAddr.size() > 0 && adOut == expAddr[0], "R2 R7 address phase", adOut,
              expAddr.size() > 0 ? expAddr[0] : 0);
        check(cbeOut == expCmd, "R2 command", cbeOut, expCmd);
        tAddr = adOut;
        tenureWords = 0;
        tenureGntOk = !gntN;
        turnPending = !expWrite;
      end else if (turnPending) begin
        check(!adOe && irdyN && !frameN, "R4 turnaround", {adOe, irdyN, frameN}, 3'b010);
        turnPending = 0;
      end
      if (!irdyN && tenureGntOk)
        check(frameN == (reqRemain == 1), "R5 frame marks last word", frameN, reqRemain == 1);
      if (!irdyN && prevGnt)
        check(frameN, "R8 frame up after grant loss", frameN, 1);

      // target response
      if (!irdyN) begin
        trdyN = (stallMode == 1) ? cyc[0] : 1'b0;
        stopN = 1'b1;
        if (stopArm && tenureWords == stopAt) begin
          stopN = 1'b0;
          trdyN = !stopWithData;
          stopArm = 0;
          discExpect = tenureWords + (stopWithData ? 1 : 0);
        end
        adIn = rdWord(tAddr);
      end else begin
        trdyN = 1'b1;
        stopN = 1'b1;
      end
      #1;
      xferNow = !irdyN && !trdyN;
      check(wrTake == (xferNow && expWrite), "R3 write take strobe", wrTake, xferNow && expWrite);
      if (xferNow) begin
        if (expWrite) begin
          check(expAddr.size() > 0 && tAddr == expAddr[0], "R3 write address", tAddr,
                expAddr.size() > 0 ? expAddr[0] : 0);
          check(expData.size() > 0 && adOut == expData[0], "R3 write word", adOut,
                expData.size() > 0 ? expData[0] : 0);
          if (expData.size() > 0) begin
            void'(expAddr.pop_front());
            void'(expData.pop_front());
          end
          wrData = (expData.size() > 0) ? expData[0] : '0;
        end
        tAddr = tAddr + 4;
        tenureWords++;
        reqRemain--;
        if (frameN) endFlag = 1;
      end
      if (!stopN) endFlag = 1;

      if (gntArm && !irdyN && (reqTotal - reqRemain) >= gntDropAt) begin
        gntN = 1'b1;
        gntHold = 4;
        gntArm = 0;
      end else if (gntHold > 0) begin
        gntHold--;
        if (gntHold == 0) gntN = 1'b0;
      end
      prevFrame = frameN;
      prevIrdy = irdyN;
      prevGnt = gntN;
    end
  end

  task automatic doBurst(input logic [CMD_W-1:0] cmd, input logic [DATA_W-1:0] addr,
                         input int count, input int stall, input int stopWord,
                         input bit stopData, input int gntWord);
    for (int i = 0; i < count; i++) begin
      logic [DATA_W-1:0] a;
      a = addr + 32'(4 * i);
      expAddr.push_back(a);
      expData.push_back(cmd[0] ? (32'hC0DE_0000 ^ a ^ 32'(i * 257)) : rdWord(a));
    end
    expCmd = cmd;
    expWrite = cmd[0];
    reqRemain = count;
    reqTotal = count;
    stallMode = stall;
    stopArm = (stopWord >= 0);
    stopAt = stopWord;
    stopWithData = stopData;
    gntArm = (gntWord >= 0);
    gntDropAt = gntWord;
    doneSeen = 0;
    @(negedge clk);
    wrData = cmd[0] ? expData[0] : '0;
    check(reqReady, "R9 ready before request", reqReady, 1);
    reqValid = 1'b1;
    reqCmd = cmd;
    reqAddr = addr;
    reqCount = CNT_W'(count);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R9 busy after accept", reqReady, 0);
    for (int t = 0; t < 3000 && !doneSeen; t++) @(posedge clk);
    check(doneSeen, "R9 request completed", doneSeen, 1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(frameN && irdyN, "R1 lines idle in reset", {frameN, irdyN}, 2'b11);
    check(!adOe && reqReady && !doneValid, "R1 outputs in reset", {adOe, reqReady, doneValid}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    check(frameN && irdyN && reqReady, "R1 idle after reset", {frameN, irdyN, reqReady}, 3'b111);

    doBurst(4'h7, 32'h0000_1000, 4, 0, -1, 0, -1);   // R3 write, no stalls
    doBurst(4'h6, 32'h0000_2000, 4, 0, -1, 0, -1);   // R4 read, no stalls
    doBurst(4'h7, 32'h0000_3000, 1, 0, -1, 0, -1);   // R5 single-word write
    doBurst(4'h6, 32'h0000_3100, 1, 1, -1, 0, -1);   // R5 single-word read, stalled
    doBurst(4'h7, 32'h0000_4000, 8, 1, -1, 0, -1);   // R3 stalled write
    doBurst(4'h6, 32'h0000_5000, 6, 1, -1, 0, -1);   // R4 stalled read
    doBurst(4'h7, 32'h0000_6000, 6, 0, 2, 1, -1);    // R6 R7 stop with data
    doBurst(4'h6, 32'h0000_7000, 7, 1, 3, 0, -1);    // R6 R7 stop without data
    doBurst(4'h7, 32'h0000_8000, 10, 0, -1, 0, 3);   // R8 R7 grant removed
    doBurst(4'h6, 32'h0000_9000, 9, 1, -1, 0, 4);    // R8 grant removed on read
    doBurst(4'h6, 32'hFFFF_FF80, 40, 0, -1, 0, -1);  // R10 long burst across wrap
    doBurst(4'h7, 32'h0001_0000, 40, 1, 20, 1, -1);  // R10 R6 long write with stop

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule